// File: doc/BRIEF.md
# Paged NIC Host Register Interface

This block is the register file a host processor sees when it drives a small Ethernet controller. The host reaches it through an 8-bit data bus with a 4-bit offset and separate read and write strobes. Sixteen offsets are too few for every register, so the registers are banked into pages. The active page comes from two bits of the command register, and that register stays reachable at offset 0x00 on every page. Besides the page select, the command register carries the start/stop control, a transmit request and a 3-bit remote-DMA command. Each of these drives an output to the datapath.

The receive, transmit and DMA engines report events to the block through single-cycle pulses. Each pulse sets a bit in an interrupt status register, and the host clears a bit by writing 1 to it. A mask register chooses which status bits may assert the single interrupt line. Three saturating tally counters count alignment errors, CRC errors and missed packets. A host read of a counter clears it, and a counter reaching its upper half raises a status bit of its own. Page 1 holds the station address, the current receive page and the multicast filter bytes, and each of these is also driven out in parallel to the filtering logic.

Top module: `nic_host_regs`

## Requirements
- R1: After reset the command register reads 0x01 (stopped, page 0, no transmit, DMA command 0), the interrupt status reads 0x00, irq is low, tx_req is low, rx_cfg is 0x00 and every tally counter reads 0.
- R2: Command register bit fields are: bit 0 = stop, bit 1 = start (stop wins if both are written), bit 2 = transmit request, bits 5:3 = DMA command, bits 7:6 = page. It reads back as {page, dma_cmd, tx busy, running, not running} at offset 0x00 on every page. Other offsets decode against the page written last.
- R3: On page 1, offsets 0x01-0x06 are station-address bytes 0-5 (offset 0x01 drives station_addr[7:0]), offset 0x07 is cur_page, and offsets 0x08-0x0F are multicast bytes 0-7 (offset 0x08 drives mcast_filter[7:0]). All of them are read/write. On page 0, offset 0x01 reads 0x00.
- R4: Interrupt status at page-0 offset 0x07 has bit 0 = rx ok, bit 1 = tx ok, bit 2 = rx error, bit 3 = tx error, bit 4 = overwrite, bit 5 = counter overflow, bit 6 = DMA done and bit 7 = stopped-and-quiet. An event pulse sets its bit on the next clock edge. Writing 1 clears a bit and writing 0 leaves it unchanged. An event in the same cycle as a clear leaves the bit set.
- R5: The mask (write at page-0 offset 0x0F, read back at page-2 offset 0x0F) covers status bits 0-6. irq goes high one cycle after (status AND mask) becomes nonzero and goes low one cycle after it becomes zero.
- R6: Status bit 7 sets while the controller is stopped and core_idle is high. A start command clears it, and it is never routed to irq.
- R7: A write with bit 2 set raises tx_req only if the controller is running after that write, and it is ignored while stopped. tx_req reads back as command bit 2 and falls on the cycle after an ev_tx_ok or ev_tx_err pulse.
- R8: Page-0 offsets 0x0D, 0x0E and 0x0F read the alignment, CRC and missed-packet counters. A read returns the value and clears the counter. Counters stop at 0xFF.
- R9: When a counter's bit 7 goes from 0 to 1, status bit 5 sets.
- R10: Alignment and CRC counters count only while running. The missed-packet counter also counts while stopped if rx_cfg bit 5 (monitor) is set. rx_cfg is written at page-0 offset 0x0C and read back at page-2 offset 0x0C.
- R11: bus_rdata is registered: it presents the addressed value in the cycle after a bus_rd strobe and holds it until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request |
| core_idle | input | 1 | Datapath reports no activity |
| ev_rx_ok | input | 1 | Packet received pulse |
| ev_rx_err | input | 1 | Receive error pulse |
| ev_tx_ok | input | 1 | Packet transmitted pulse |
| ev_tx_err | input | 1 | Transmit error pulse |
| ev_ovw | input | 1 | Receive ring overwrite warning pulse |
| ev_dma_done | input | 1 | Remote DMA finished pulse |
| cnt_align | input | 1 | Alignment error increment |
| cnt_crc | input | 1 | CRC error increment |
| cnt_miss | input | 1 | Missed packet increment |
| ctl_running | output | 1 | Controller started |
| tx_req | output | 1 | Transmit in progress |
| dma_cmd | output | 3 | Remote DMA command |
| rx_cfg | output | 8 | Receive configuration |
| station_addr | output | 48 | Station address, byte 0 in bits 7:0 |
| cur_page | output | 8 | Current receive page |
| mcast_filter | output | 64 | Multicast filter, byte 0 in bits 7:0 |

## Verification
Some properties are checked every cycle: status bits set after an event pulse, tx_req drops after a transmit completion, the counters hold at saturation, bit 7 sets while stopped and quiet, irq stays low under an all-zero mask, and read data holds between strobes. Other behaviour only the directed scenarios can show. That includes bank switching and the decode of each page, set winning over a same-cycle clear, read-to-clear counters, the 128th increment raising the overflow bit, and monitor mode gating the missed-packet counter while stopped.

// File: rtl/nic_regs_pkg.sv
package nic_regs_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;

  typedef enum logic [1:0] {PG0 = 2'd0, PG1 = 2'd1, PG2 = 2'd2, PG3 = 2'd3} page_e;

  localparam logic [ADDR_W-1:0] OFS_CMD    = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_ISR    = 4'h7;
  localparam logic [ADDR_W-1:0] OFS_RCFG   = 4'hC;
  localparam logic [ADDR_W-1:0] OFS_IMASK  = 4'hF;
  localparam logic [ADDR_W-1:0] OFS_TALLY0 = 4'hD;

  localparam int CB_STOP  = 0;
  localparam int CB_START = 1;
  localparam int CB_TX    = 2;

  localparam int SB_RXOK = 0;
  localparam int SB_TXOK = 1;
  localparam int SB_RXER = 2;
  localparam int SB_TXER = 3;
  localparam int SB_OVW  = 4;
  localparam int SB_CNT  = 5;
  localparam int SB_DMA  = 6;
  localparam int SB_QUIET = 7;
  localparam int NUM_MASKED = 7;

  localparam int RCFG_MON = 5;
endpackage

// File: rtl/nic_cmd_ctrl.sv
module nic_cmd_ctrl
  import nic_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tx_done,
  output logic              running,
  output page_e             page,
  output logic [2:0]        dma_cmd,
  output logic              tx_busy,
  output logic [DATA_W-1:0] cmd_rd
);
  logic run_next;

  always_comb begin
    run_next = running;
    if (cmd_we) begin
      if (wdata[CB_STOP])       run_next = 1'b0;
      else if (wdata[CB_START]) run_next = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      page    <= PG0;
      dma_cmd <= '0;
      tx_busy <= 1'b0;
    end else begin
      running <= run_next;
      if (cmd_we) begin
        page    <= page_e'(wdata[7:6]);
        dma_cmd <= wdata[5:3];
      end
      if (cmd_we && wdata[CB_TX] && run_next) tx_busy <= 1'b1;
      else if (tx_done)                       tx_busy <= 1'b0;
    end
  end

  assign cmd_rd = {page, dma_cmd, tx_busy, running, ~running};
endmodule

// File: rtl/nic_int_ctrl.sv
module nic_int_ctrl
  import nic_regs_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_MASKED-1:0] ev,
  input  logic                  quiet_cond,
  input  logic                  start_cmd,
  input  logic                  isr_we,
  input  logic                  mask_we,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     isr,
  output logic [NUM_MASKED-1:0] mask,
  output logic                  irq
);
  logic [DATA_W-1:0] clr;
  assign clr = isr_we ? wdata : '0;

  genvar b;
  generate
    for (b = 0; b < NUM_MASKED; b++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst) isr[b] <= 1'b0;
        else     isr[b] <= (isr[b] & ~clr[b]) | ev[b];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)             isr[SB_QUIET] <= 1'b0;
    else if (start_cmd)  isr[SB_QUIET] <= 1'b0;
    else if (quiet_cond) isr[SB_QUIET] <= 1'b1;
    else                 isr[SB_QUIET] <= isr[SB_QUIET] & ~clr[SB_QUIET];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= '0;
      irq  <= 1'b0;
    end else begin
      if (mask_we) mask <= wdata[NUM_MASKED-1:0];
      irq <= |(isr[NUM_MASKED-1:0] & mask);
    end
  end
endmodule

// File: rtl/nic_tally_cnt.sv
module nic_tally_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] cnt,
  output logic         msb_rise
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  logic [W-1:0] nxt;

  always_comb begin
    if (clr)                     nxt = inc ? W'(1) : '0;
    else if (inc && cnt != TOP)  nxt = cnt + W'(1);
    else                         nxt = cnt;
  end

  assign msb_rise = nxt[W-1] & ~cnt[W-1];

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= nxt;
  end
endmodule

// File: rtl/nic_host_regs.sv
module nic_host_regs
  import nic_regs_pkg::*;
#(
  parameter int NUM_TALLY = 3,
  parameter int SA_BYTES  = 6,
  parameter int MC_BYTES  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  output logic [DATA_W-1:0]        bus_rdata,
  output logic                     irq,
  input  logic                     core_idle,
  input  logic                     ev_rx_ok,
  input  logic                     ev_rx_err,
  input  logic                     ev_tx_ok,
  input  logic                     ev_tx_err,
  input  logic                     ev_ovw,
  input  logic                     ev_dma_done,
  input  logic                     cnt_align,
  input  logic                     cnt_crc,
  input  logic                     cnt_miss,
  output logic                     ctl_running,
  output logic                     tx_req,
  output logic [2:0]               dma_cmd,
  output logic [DATA_W-1:0]        rx_cfg,
  output logic [8*SA_BYTES-1:0]    station_addr,
  output logic [DATA_W-1:0]        cur_page,
  output logic [8*MC_BYTES-1:0]    mcast_filter
);
  localparam int P1_LAST = SA_BYTES + 1 + MC_BYTES;
  localparam int CUR_OFS = SA_BYTES + 1;

  logic              running;
  page_e             page;
  logic              tx_busy;
  logic [DATA_W-1:0] cmd_rd;
  logic              cmd_we, isr_we, mask_we, rcfg_we, p1_we, start_cmd, tx_done;
  logic [DATA_W-1:0] isr;
  logic [NUM_MASKED-1:0] mask;
  logic [NUM_MASKED-1:0] ev;
  logic [NUM_TALLY-1:0][DATA_W-1:0] tally_val;
  logic [NUM_TALLY-1:0] tally_inc, tally_clr, tally_rise;
  logic [DATA_W-1:0] p1_mem [1:P1_LAST];
  logic [DATA_W-1:0] rd_val;

  assign cmd_we    = bus_wr && bus_addr == OFS_CMD;
  assign isr_we    = bus_wr && page == PG0 && bus_addr == OFS_ISR;
  assign mask_we   = bus_wr && page == PG0 && bus_addr == OFS_IMASK;
  assign rcfg_we   = bus_wr && page == PG0 && bus_addr == OFS_RCFG;
  assign p1_we     = bus_wr && page == PG1 && bus_addr != OFS_CMD;
  assign start_cmd = cmd_we && !bus_wdata[CB_STOP] && bus_wdata[CB_START];
  assign tx_done   = ev_tx_ok | ev_tx_err;

  nic_cmd_ctrl u_cmd (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .wdata(bus_wdata), .tx_done(tx_done),
    .running(running), .page(page), .dma_cmd(dma_cmd), .tx_busy(tx_busy), .cmd_rd(cmd_rd)
  );

  assign ev[SB_RXOK] = ev_rx_ok;
  assign ev[SB_TXOK] = ev_tx_ok;
  assign ev[SB_RXER] = ev_rx_err;
  assign ev[SB_TXER] = ev_tx_err;
  assign ev[SB_OVW]  = ev_ovw;
  assign ev[SB_CNT]  = |tally_rise;
  assign ev[SB_DMA]  = ev_dma_done;

  nic_int_ctrl u_int (
    .clk(clk), .rst(rst), .ev(ev), .quiet_cond(!running && core_idle),
    .start_cmd(start_cmd), .isr_we(isr_we), .mask_we(mask_we), .wdata(bus_wdata),
    .isr(isr), .mask(mask), .irq(irq)
  );

  // Increment gating: index 0 alignment, 1 CRC, 2 missed packet.
  always_comb begin
    tally_inc = '0;
    tally_inc[0] = cnt_align & running;
    if (NUM_TALLY > 1) tally_inc[1] = cnt_crc & running;
    if (NUM_TALLY > 2) tally_inc[2] = cnt_miss & (running | rx_cfg[RCFG_MON]);
  end

  genvar t;
  generate
    for (t = 0; t < NUM_TALLY; t++) begin : g_tally
      assign tally_clr[t] = bus_rd && page == PG0 && bus_addr == ADDR_W'(OFS_TALLY0 + t);
      nic_tally_cnt #(.W(DATA_W)) u_cnt (
        .clk(clk), .rst(rst), .inc(tally_inc[t]), .clr(tally_clr[t]),
        .cnt(tally_val[t]), .msb_rise(tally_rise[t])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) rx_cfg <= '0;
    else if (rcfg_we) rx_cfg <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 1; i <= P1_LAST; i++) p1_mem[i] <= '0;
    end else if (p1_we) begin
      p1_mem[bus_addr] <= bus_wdata;
    end
  end

  genvar g;
  generate
    for (g = 0; g < SA_BYTES; g++) begin : g_sa
      assign station_addr[8*g +: 8] = p1_mem[1 + g];
    end
    for (g = 0; g < MC_BYTES; g++) begin : g_mc
      assign mcast_filter[8*g +: 8] = p1_mem[CUR_OFS + 1 + g];
    end
  endgenerate
  assign cur_page = p1_mem[CUR_OFS];

  always_comb begin
    rd_val = '0;
    if (bus_addr == OFS_CMD) begin
      rd_val = cmd_rd;
    end else begin
      unique case (page)
        PG0: begin
          if (bus_addr == OFS_ISR) rd_val = isr;
          for (int i = 0; i < NUM_TALLY; i++)
            if (bus_addr == ADDR_W'(OFS_TALLY0 + i)) rd_val = tally_val[i];
        end
        PG1: rd_val = p1_mem[bus_addr];
        PG2: begin
          if (bus_addr == OFS_RCFG)  rd_val = rx_cfg;
          if (bus_addr == OFS_IMASK) rd_val = {1'b0, mask};
        end
        default: rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

  assign ctl_running = running;
  assign tx_req      = tx_busy;
endmodule

// File: rtl/nic_host_regs_chk.sv
module nic_host_regs_chk
  import nic_regs_pkg::*;
#(
  parameter int NUM_TALLY = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bus_rd,
  input logic [DATA_W-1:0]     bus_rdata,
  input logic                  bus_wr,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [DATA_W-1:0]     bus_wdata,
  input logic                  irq,
  input logic                  core_idle,
  input logic                  ev_rx_ok,
  input logic                  ev_tx_ok,
  input logic                  ev_tx_err,
  input logic                  tx_req,
  input logic                  running,
  input logic [DATA_W-1:0]     isr,
  input logic [NUM_MASKED-1:0] mask,
  input logic [NUM_TALLY-1:0][DATA_W-1:0] tally_val,
  input logic [NUM_TALLY-1:0]  tally_clr,
  input logic [NUM_TALLY-1:0]  tally_rise
);
  logic cmd_wr;
  assign cmd_wr = bus_wr && bus_addr == OFS_CMD;

  assert_rxok_sets_R4: assert property (@(posedge clk) disable iff (rst)
    ev_rx_ok |=> isr[SB_RXOK]);

  assert_mask_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |=> !irq);

  assert_quiet_sets_R6: assert property (@(posedge clk) disable iff (rst)
    (!running && core_idle && !cmd_wr) |=> isr[SB_QUIET]);

  assert_txdone_drops_R7: assert property (@(posedge clk) disable iff (rst)
    ((ev_tx_ok || ev_tx_err) && !(cmd_wr && bus_wdata[CB_TX])) |=> !tx_req);

  assert_ovf_flag_R9: assert property (@(posedge clk) disable iff (rst)
    (|tally_rise) |=> isr[SB_CNT]);

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  genvar k;
  generate
    for (k = 0; k < NUM_TALLY; k++) begin : g_sat
      assert_tally_sat_R8: assert property (@(posedge clk) disable iff (rst)
        (tally_val[k] == {DATA_W{1'b1}} && !tally_clr[k]) |=> tally_val[k] == {DATA_W{1'b1}});
    end
  endgenerate
endmodule

bind nic_host_regs nic_host_regs_chk #(.NUM_TALLY(NUM_TALLY)) u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq(irq), .core_idle(core_idle),
  .ev_rx_ok(ev_rx_ok), .ev_tx_ok(ev_tx_ok), .ev_tx_err(ev_tx_err), .tx_req(tx_req),
  .running(running), .isr(isr), .mask(mask), .tally_val(tally_val),
  .tally_clr(tally_clr), .tally_rise(tally_rise)
);

// File: tb/test_nic_host_regs.sv
`timescale 1ns/100ps
module test_nic_host_regs;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic irq, core_idle = 1'b0;
  logic ev_rx_ok = 0, ev_rx_err = 0, ev_tx_ok = 0, ev_tx_err = 0, ev_ovw = 0, ev_dma_done = 0;
  logic cnt_align = 0, cnt_crc = 0, cnt_miss = 0;
  logic ctl_running, tx_req;
  logic [2:0] dma_cmd;
  logic [7:0] rx_cfg, cur_page;
  logic [47:0] station_addr;
  logic [63:0] mcast_filter;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  nic_host_regs i_nic_host_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq), .core_idle(core_idle),
    .ev_rx_ok(ev_rx_ok), .ev_rx_err(ev_rx_err), .ev_tx_ok(ev_tx_ok), .ev_tx_err(ev_tx_err),
    .ev_ovw(ev_ovw), .ev_dma_done(ev_dma_done), .cnt_align(cnt_align), .cnt_crc(cnt_crc),
    .cnt_miss(cnt_miss), .ctl_running(ctl_running), .tx_req(tx_req), .dma_cmd(dma_cmd),
    .rx_cfg(rx_cfg), .station_addr(station_addr), .cur_page(cur_page),
    .mcast_filter(mcast_filter)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(4'h0, d); check("R1 cmd after reset", d, 8'h01);
    rd(4'h7, d); check("R1 status after reset", d, 8'h00);
    rd(4'hD, d); check("R1 align tally after reset", d, 8'h00);
    check("R1 irq low", irq, 0);
    check("R1 tx_req low", tx_req, 0);
    check("R1 rx_cfg zero", rx_cfg, 0);
  endtask

  task automatic t_paging;
    logic [7:0] d;
    wr(4'h0, 8'h40);
    rd(4'h0, d); check("R2 cmd on page 1", d, 8'h41);
    for (int i = 1; i <= 6; i++) wr(4'(i), 8'(8'h10 + i));
    wr(4'h7, 8'h46);
    for (int i = 8; i <= 15; i++) wr(4'(i), 8'(8'hA0 + i));
    check("R3 station_addr", station_addr, 48'h161514131211);
    check("R3 cur_page", cur_page, 8'h46);
    check("R3 mcast_filter", mcast_filter, 64'hAFAEADACABAAA9A8);
    rd(4'h3, d); check("R3 page1 addr byte readback", d, 8'h13);
    rd(4'hC, d); check("R3 page1 mcast readback", d, 8'hAC);
    wr(4'h0, 8'h28);
    check("R2 dma_cmd field", dma_cmd, 3'd5);
    rd(4'h0, d); check("R2 cmd on page 0 with dma", d, 8'h29);
    rd(4'h1, d); check("R3 page0 offset1 not station", d, 8'h00);
    wr(4'h0, 8'h00);
  endtask

  task automatic t_transmit;
    logic [7:0] d;
    wr(4'h0, 8'h04);
    check("R7 txp ignored while stopped", tx_req, 0);
    wr(4'h0, 8'h03);
    check("R2 stop wins over start", ctl_running, 0);
    wr(4'h0, 8'h02);
    rd(4'h0, d); check("R2 started cmd readback", d, 8'h02);
    wr(4'h0, 8'h06);
    check("R7 tx_req raised", tx_req, 1);
    rd(4'h0, d); check("R7 txp reads back busy", d, 8'h06);
    @(negedge clk) ev_tx_ok = 1'b1;
    @(negedge clk) ev_tx_ok = 1'b0;
    check("R7 tx_req falls on done", tx_req, 0);
    rd(4'h7, d); check("R4 tx ok status", d, 8'h02);
    wr(4'h7, 8'h02);
    rd(4'h7, d); check("R4 w1c clears", d, 8'h00);
  endtask

  task automatic t_interrupts;
    logic [7:0] d;
    wr(4'hF, 8'h01);
    @(negedge clk) ev_rx_ok = 1'b1;
    @(negedge clk) ev_rx_ok = 1'b0;
    check("R5 irq lags status by one cycle", irq, 0);
    @(negedge clk);
    check("R5 irq raised", irq, 1);
    @(negedge clk) ev_ovw = 1'b1;
    @(negedge clk) ev_ovw = 1'b0;
    wr(4'h7, 8'h01);
    @(negedge clk);
    check("R5 irq drops, masked bit left", irq, 0);
    rd(4'h7, d); check("R4 write 0 leaves bit", d, 8'h10);
    @(negedge clk);
    bus_addr = 4'h7; bus_wdata = 8'h04; bus_wr = 1'b1; ev_rx_err = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; ev_rx_err = 1'b0;
    rd(4'h7, d); check("R4 set wins over clear", d, 8'h14);
    wr(4'h7, 8'hFF);
    rd(4'h7, d); check("R4 clear all", d, 8'h00);
    wr(4'h0, 8'h82);
    rd(4'hF, d); check("R5 mask readback page 2", d, 8'h01);
    rd(4'hC, d); check("R10 rx_cfg readback page 2", d, 8'h00);
    wr(4'h0, 8'h02);
  endtask

  task automatic t_tally;
    logic [7:0] d;
    wr(4'hF, 8'h20);
    @(negedge clk) cnt_crc = 1'b1;
    idle(3);
    cnt_crc = 1'b0;
    rd(4'hE, d); check("R8 crc count", d, 8'd3);
    rd(4'hE, d); check("R8 read clears", d, 8'd0);
    @(negedge clk) cnt_align = 1'b1;
    idle(127);
    cnt_align = 1'b0;
    rd(4'h7, d); check("R9 no overflow at 127", d, 8'h00);
    @(negedge clk) cnt_align = 1'b1;
    @(negedge clk) cnt_align = 1'b0;
    rd(4'h7, d); check("R9 overflow at 128", d, 8'h20);
    check("R9 overflow drives irq", irq, 1);
    @(negedge clk) cnt_align = 1'b1;
    idle(200);
    cnt_align = 1'b0;
    rd(4'hD, d); check("R8 saturates", d, 8'hFF);
    idle(3);
    check("R11 rdata held", bus_rdata, 8'hFF);
    rd(4'hD, d); check("R8 cleared after saturation", d, 8'h00);
    wr(4'h7, 8'hFF);
  endtask

  task automatic t_monitor;
    logic [7:0] d;
    wr(4'h0, 8'h01);
    @(negedge clk) cnt_miss = 1'b1;
    idle(2);
    cnt_miss = 1'b0;
    rd(4'hF, d); check("R10 missed idle while stopped", d, 8'd0);
    wr(4'hC, 8'h20);
    check("R10 rx_cfg written", rx_cfg, 8'h20);
    @(negedge clk) cnt_miss = 1'b1;
    idle(3);
    cnt_miss = 1'b0;
    @(negedge clk) cnt_align = 1'b1;
    idle(2);
    cnt_align = 1'b0;
    rd(4'hF, d); check("R10 missed counts in monitor", d, 8'd3);
    rd(4'hD, d); check("R10 align idle while stopped", d, 8'd0);
  endtask

  task automatic t_quiet;
    logic [7:0] d;
    wr(4'h7, 8'hFF);
    core_idle = 1'b1;
    idle(1);
    rd(4'h7, d); check("R6 quiet bit set", d, 8'h80);
    check("R6 quiet bit not on irq", irq, 0);
    wr(4'h0, 8'h02);
    rd(4'h7, d); check("R6 start clears quiet", d, 8'h00);
    core_idle = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung run, expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    t_reset();
    t_paging();
    t_transmit();
    t_interrupts();
    t_tally();
    t_monitor();
    t_quiet();
    idle(2);
    finish_run();
  end
endmodule